// File: doc/BRIEF.md
# Multi-Mode UART with Address Detect

This block is a full-duplex asynchronous serial transceiver. A 16-bit divisor sets an oversampling tick at sixteen times the bit rate. The transmit and receive sides share that tick and the frame settings. A frame carries either 8 data bits, with optional even or odd parity, or 9 data bits with no parity. It ends with one or two stop bits.

Each direction has a four-entry buffer. Software pushes words into the transmit buffer, and a shifter serializes them least significant bit first. The receiver samples each bit three times and takes the majority. It places each finished word into its buffer together with that word's parity-error and framing-error flags. A frame that finishes while the buffer is full is dropped and sets a sticky overrun flag.

In address-detect mode the receiver works in 9-bit frames and keeps only the frames whose ninth bit is set. Frames with a clear ninth bit therefore cause no interrupt. Loopback mode feeds the transmit stream back into the receiver and holds the external line idle.

Top module: `uart_addr_xcvr`

## Requirements
- R1: One bit lasts 16 × (cfg_divisor + 1) clock cycles on both the transmit and the receive side.
- R2: A frame is a 0 start bit, then the data bits least significant bit first, then the stop bits at 1. The frame has 9 data bits when cfg_nine_bit or cfg_addr_detect is set, and 8 otherwise.
- R3: cfg_parity uses 2'b01 for even and 2'b10 for odd; 2'b00 and 2'b11 mean no parity. A parity bit follows the data only in 8-bit frames. In 9-bit frames the parity setting has no effect on either side.
- R4: With cfg_two_stop set, the transmitter sends two stop bits. The receiver checks only the first stop bit.
- R5: Four words can wait in the transmit buffer while the shifter holds a fifth. tx_full is high when four are waiting, and a write while full is dropped.
- R6: The receive buffer holds four words. A kept frame that finishes while the buffer is full is discarded and sets rx_overrun. rx_overrun stays set until an ovr_clear pulse.
- R7: Each stored word carries rx_perr, set when the received parity bit does not match its data, and rx_ferr, set when the first stop bit is sampled as 0.
- R8: With cfg_addr_detect set, a frame whose ninth bit is 0 is not stored. A frame whose ninth bit is 1 is stored.
- R9: tx_irq is the registered state of "transmit buffer not full". rx_irq is the registered state of "receive buffer not empty".
- R10: With cfg_loopback set, txd stays 1 and the receiver takes the internal transmit stream in place of rxd.
- R11: While rst is high, txd is 1, rx_empty is 1, and tx_full, tx_irq, rx_irq and rx_overrun are 0.
- R12: Each bit is decided by a majority of the samples taken at ticks 7, 8 and 9 of 16. A low pulse on an idle line that does not cover those samples starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_divisor | input | 16 | Tick divisor; tick rate = clk / (divisor + 1) |
| cfg_nine_bit | input | 1 | 9-bit frames |
| cfg_parity | input | 2 | 01 even, 10 odd, other values none |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_addr_detect | input | 1 | Keep only frames whose ninth bit is set |
| cfg_loopback | input | 1 | Internal loopback, txd held high |
| tx_data | input | 9 | Word to send |
| tx_write | input | 1 | Push tx_data into the transmit buffer |
| tx_full | output | 1 | Transmit buffer full |
| tx_irq | output | 1 | Transmit interrupt |
| rx_data | output | 9 | Oldest received word |
| rx_perr | output | 1 | Parity error of rx_data |
| rx_ferr | output | 1 | Framing error of rx_data |
| rx_read | input | 1 | Pop the oldest received word |
| rx_empty | output | 1 | Receive buffer empty |
| rx_irq | output | 1 | Receive interrupt |
| rx_overrun | output | 1 | Sticky overrun flag |
| ovr_clear | input | 1 | Clear rx_overrun |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The assertions check several properties on every cycle: the tick spacing, the line level in the start and stop states, that a full buffer never takes a word, that overrun is set when a kept frame meets a full buffer, and that address-detect mode stores only words with the ninth bit set. They also check that the loopback line stays quiet and that the interrupts follow the buffer state. Some behaviours only the bench scenarios can show. These are the bit order and bit duration on the wire, the parity and framing flags, the rejection of glitches, the dropped sixth write and the discarded fifth frame. The bench shows them by decoding txd and driving rxd against queues of expected words.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int OSR = 16;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } parity_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } ser_state_e;

  function automatic logic parity_on(input logic nine, input logic [1:0] mode);
    return !nine && (mode == PAR_EVEN || mode == PAR_ODD);
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] mode);
    return (mode == PAR_ODD) ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= divisor;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: a nonzero divisor leaves at least one idle cycle between ticks
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor != '0 && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5 / R6: a full buffer refuses a write that has no matching read
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !rd) |=> full);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       nine,
  input  logic [1:0] parity,
  input  logic       two_stop,
  input  logic       buf_empty,
  input  logic [8:0] buf_data,
  output logic       buf_rd,
  output logic       line
);
  ser_state_e state;
  logic [8:0] sh;
  logic [3:0] tcnt;
  logic [3:0] idx;
  logic       stop_n;
  logic       par_bit;
  logic [3:0] last_idx;

  assign buf_rd   = (state == S_IDLE) && !buf_empty;
  assign last_idx = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      line    <= 1'b1;
      sh      <= '0;
      tcnt    <= '0;
      idx     <= '0;
      stop_n  <= 1'b0;
      par_bit <= 1'b0;
    end else if (state == S_IDLE) begin
      line <= 1'b1;
      if (!buf_empty) begin
        sh      <= buf_data;
        par_bit <= parity_of(buf_data[7:0], parity);
        state   <= S_START;
        line    <= 1'b0;
        tcnt    <= '0;
      end
    end else if (tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == 4'd15) begin
        case (state)
          S_START: begin
            state <= S_DATA;
            idx   <= '0;
            line  <= sh[0];
          end
          S_DATA: begin
            if (idx == last_idx) begin
              if (parity_on(nine, parity)) begin
                state <= S_PAR;
                line  <= par_bit;
              end else begin
                state  <= S_STOP;
                stop_n <= 1'b0;
                line   <= 1'b1;
              end
            end else begin
              idx  <= idx + 1'b1;
              sh   <= sh >> 1;
              line <= sh[1];
            end
          end
          S_PAR: begin
            state  <= S_STOP;
            stop_n <= 1'b0;
            line   <= 1'b1;
          end
          default: begin
            if (two_stop && !stop_n) stop_n <= 1'b1;
            else                     state  <= S_IDLE;
          end
        endcase
      end
    end
  end

  // R2: start bit is low, stop bits are high
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> !line);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP) |-> line);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        rx_in,
  input  logic        nine,
  input  logic [1:0]  parity,
  input  logic        addr_mode,
  input  logic        ovr_clear,
  input  logic        buf_full,
  output logic        wr,
  output logic [10:0] wdata,
  output logic        overrun
);
  ser_state_e state;
  logic [3:0] tcnt;
  logic [3:0] idx;
  logic       s7, s8;
  logic [8:0] data;
  logic       par_rx;
  logic       vote;
  logic [8:0] word_c;
  logic       perr_c, keep_c, done_c;
  logic [3:0] last_idx;

  assign vote     = (s7 & s8) | (s7 & rx_in) | (s8 & rx_in);
  assign last_idx = nine ? 4'd8 : 4'd7;
  assign word_c   = nine ? data : {1'b0, data[8:1]};
  assign perr_c   = parity_on(nine, parity) && (par_rx != parity_of(word_c[7:0], parity));
  assign keep_c   = !addr_mode || word_c[8];
  assign done_c   = tick && (state == S_STOP) && (tcnt == 4'd9);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      tcnt    <= '0;
      idx     <= '0;
      s7      <= 1'b1;
      s8      <= 1'b1;
      data    <= '0;
      par_rx  <= 1'b0;
      wr      <= 1'b0;
      wdata   <= '0;
      overrun <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (ovr_clear) overrun <= 1'b0;
      if (tick) begin
        if (state == S_IDLE) begin
          if (!rx_in) begin
            state <= S_START;
            tcnt  <= 4'd1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7) s7 <= rx_in;
          if (tcnt == 4'd8) s8 <= rx_in;
          if (tcnt == 4'd9) begin
            case (state)
              S_START: if (vote) state <= S_IDLE;
              S_DATA:  data   <= {vote, data[8:1]};
              S_PAR:   par_rx <= vote;
              S_STOP: begin
                state <= S_IDLE;
                if (keep_c) begin
                  if (buf_full) overrun <= 1'b1;
                  else begin
                    wr    <= 1'b1;
                    wdata <= {word_c, perr_c, !vote};
                  end
                end
              end
              default: state <= S_IDLE;
            endcase
          end
          if (tcnt == 4'd15) begin
            case (state)
              S_START: begin
                state <= S_DATA;
                idx   <= '0;
              end
              S_DATA: begin
                if (idx == last_idx)
                  state <= parity_on(nine, parity) ? S_PAR : S_STOP;
                else
                  idx <= idx + 1'b1;
              end
              S_PAR:   state <= S_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R6: a kept frame meeting a full buffer raises the sticky flag
  p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
    (done_c && keep_c && buf_full && !ovr_clear) |=> overrun);
  // R6: overrun holds until cleared
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clear) |=> overrun);
  // R8: in address-detect mode only words with the ninth bit set are written
  p_addr_store_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && addr_mode && $stable(addr_mode)) |-> wdata[10]);
endmodule

// File: rtl/uart_addr_xcvr.sv
module uart_addr_xcvr #(
  parameter int DIV_W    = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             cfg_nine_bit,
  input  logic [1:0]       cfg_parity,
  input  logic             cfg_two_stop,
  input  logic             cfg_addr_detect,
  input  logic             cfg_loopback,
  input  logic [8:0]       tx_data,
  input  logic             tx_write,
  output logic             tx_full,
  output logic             tx_irq,
  output logic [8:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  input  logic             rx_read,
  output logic             rx_empty,
  output logic             rx_irq,
  output logic             rx_overrun,
  input  logic             ovr_clear,
  input  logic             rxd,
  output logic             txd
);
  localparam int RXW = 11;

  logic             tick;
  logic             nine_eff;
  logic             tx_empty, tx_rd, tx_line;
  logic [8:0]       tx_head;
  logic             rx_meta, rx_sync, rx_src;
  logic             rx_full, rx_wr;
  logic [RXW-1:0]   rx_wdata, rx_head;

  assign nine_eff = cfg_nine_bit | cfg_addr_detect;
  assign rx_src   = cfg_loopback ? tx_line : rxd;

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .divisor(cfg_divisor), .tick(tick)
  );

  uart_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_tx_buf (
    .clk(clk), .rst(rst), .wr(tx_write), .wdata(tx_data),
    .rd(tx_rd), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  uart_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .nine(nine_eff), .parity(cfg_parity),
    .two_stop(cfg_two_stop), .buf_empty(tx_empty), .buf_data(tx_head),
    .buf_rd(tx_rd), .line(tx_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
    end else begin
      rx_meta <= rx_src;
      rx_sync <= rx_meta;
    end
  end

  uart_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_sync), .nine(nine_eff),
    .parity(cfg_parity), .addr_mode(cfg_addr_detect), .ovr_clear(ovr_clear),
    .buf_full(rx_full), .wr(rx_wr), .wdata(rx_wdata), .overrun(rx_overrun)
  );

  uart_fifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rx_buf (
    .clk(clk), .rst(rst), .wr(rx_wr), .wdata(rx_wdata),
    .rd(rx_read), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  assign rx_data = rx_head[10:2];
  assign rx_perr = rx_head[1];
  assign rx_ferr = rx_head[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      txd    <= 1'b1;
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      txd    <= cfg_loopback ? 1'b1 : tx_line;
      tx_irq <= !tx_full;
      rx_irq <= !rx_empty;
    end
  end

  // R10: loopback keeps the external line idle
  p_loop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_loopback |=> txd);
  // R9: interrupts track buffer state one cycle later
  p_rx_irq_r9: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !rx_irq);
  p_tx_irq_r9: assert property (@(posedge clk) disable iff (rst)
    tx_full |=> !tx_irq);
endmodule

// File: tb/uart_addr_xcvr_tb.sv
module uart_addr_xcvr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_divisor;
  logic        cfg_nine_bit, cfg_two_stop, cfg_addr_detect, cfg_loopback;
  logic [1:0]  cfg_parity;
  logic [8:0]  tx_data;
  logic        tx_write, tx_full, tx_irq;
  logic [8:0]  rx_data;
  logic        rx_perr, rx_ferr, rx_read, rx_empty, rx_irq, rx_overrun;
  logic        ovr_clear, rxd, txd;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b1;

  logic [8:0]  txq[$];
  string       txtag[$];
  logic [10:0] rxq[$];
  string       rxtag[$];

  always #4 clk = ~clk;

  uart_addr_xcvr u_dut (
    .clk(clk), .rst(rst), .cfg_divisor(cfg_divisor), .cfg_nine_bit(cfg_nine_bit),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .cfg_addr_detect(cfg_addr_detect), .cfg_loopback(cfg_loopback),
    .tx_data(tx_data), .tx_write(tx_write), .tx_full(tx_full), .tx_irq(tx_irq),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_read(rx_read),
    .rx_empty(rx_empty), .rx_irq(rx_irq), .rx_overrun(rx_overrun),
    .ovr_clear(ovr_clear), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(cfg_divisor) + 1);
  endfunction

  function automatic int nbits();
    return (cfg_nine_bit || cfg_addr_detect) ? 9 : 8;
  endfunction

  function automatic bit par_used();
    return nbits() == 8 && (cfg_parity == 2'b01 || cfg_parity == 2'b10);
  endfunction

  function automatic bit par_val(input logic [7:0] d);
    return (cfg_parity == 2'b10) ? ~^d : ^d;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_put(input logic [8:0] d, input bit expect_out, input string tag);
    @(negedge clk);
    tx_data  = d;
    tx_write = 1'b1;
    if (expect_out) begin
      txq.push_back(d);
      txtag.push_back(tag);
    end
    @(negedge clk);
    tx_write = 1'b0;
  endtask

  task automatic exp_rx(input logic [8:0] d, input bit pe, input bit fe, input string tag);
    rxq.push_back({d, pe, fe});
    rxtag.push_back(tag);
  endtask

  task automatic rx_send(input logic [8:0] d, input bit wrong_par, input bit stopv);
    int b;
    b = bit_clks();
    @(negedge clk);
    rxd = 1'b0;
    wait_clks(b);
    for (int i = 0; i < nbits(); i++) begin
      rxd = d[i];
      wait_clks(b);
    end
    if (par_used()) begin
      rxd = par_val(d[7:0]) ^ wrong_par;
      wait_clks(b);
    end
    rxd = stopv;
    wait_clks(b);
    rxd = 1'b1;
    wait_clks(2 * b);
  endtask

  task automatic drain();
    while (txq.size() != 0 || rxq.size() != 0) @(negedge clk);
    wait_clks(40);
  endtask

  // Transmit line decoder (scoreboard monitor for txd)
  initial begin
    forever begin
      logic [8:0] got;
      logic [8:0] want;
      string      tag;
      int         b;
      @(negedge txd);
      b   = bit_clks();
      got = '0;
      wait_clks(b / 2);
      chk("R2", "start bit", int'(txd), 0);
      for (int i = 0; i < nbits(); i++) begin
        wait_clks(b);
        got[i] = txd;
      end
      if (par_used()) begin
        wait_clks(b);
        chk("R3", "tx parity bit", int'(txd), int'(par_val(got[7:0])));
      end
      for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
        wait_clks(b);
        chk("R4", "tx stop bit", int'(txd), 1);
      end
      if (txq.size() == 0) begin
        chk("R5", "unexpected tx frame", int'(got), 'h3ff);
      end else begin
        want = txq.pop_front();
        tag  = txtag.pop_front();
        chk(tag, "tx data (R1 bit timing)", int'(got), int'(want));
      end
    end
  end

  // Receive scoreboard
  initial begin
    rx_read = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_read) begin
        rx_read = 1'b0;
      end else if (mon_en && !rx_empty && rst == 1'b0) begin
        if (rxq.size() == 0) begin
          chk("R8", "unexpected rx word", int'(rx_data), 'h3ff);
        end else begin
          logic [10:0] e;
          string       tag;
          e   = rxq.pop_front();
          tag = rxtag.pop_front();
          chk(tag, "rx data", int'(rx_data), int'(e[10:2]));
          chk(tag, "rx perr (R7)", int'(rx_perr), int'(e[1]));
          chk(tag, "rx ferr (R7)", int'(rx_ferr), int'(e[0]));
        end
        rx_read = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_divisor = 16'd1;
    cfg_nine_bit = 1'b0;
    cfg_parity = 2'b00;
    cfg_two_stop = 1'b0;
    cfg_addr_detect = 1'b0;
    cfg_loopback = 1'b0;
    tx_data = '0;
    tx_write = 1'b0;
    ovr_clear = 1'b0;
    rxd = 1'b1;
    wait_clks(5);
    // R11 reset state
    chk("R11", "txd in reset", int'(txd), 1);
    chk("R11", "rx_empty in reset", int'(rx_empty), 1);
    chk("R11", "tx_full in reset", int'(tx_full), 0);
    chk("R11", "tx_irq in reset", int'(tx_irq), 0);
    chk("R11", "rx_irq in reset", int'(rx_irq), 0);
    chk("R11", "rx_overrun in reset", int'(rx_overrun), 0);
    rst = 1'b0;
    wait_clks(3);
    chk("R9", "tx_irq with room", int'(tx_irq), 1);

    // R2 basic 8N1 frames, both directions
    tx_put(9'h0A5, 1'b1, "R2");
    tx_put(9'h03C, 1'b1, "R2");
    exp_rx(9'h05A, 1'b0, 1'b0, "R2");
    rx_send(9'h05A, 1'b0, 1'b1);
    drain();

    // R3 even then odd parity, R7 parity error
    cfg_parity = 2'b01;
    tx_put(9'h007, 1'b1, "R3");
    exp_rx(9'h081, 1'b0, 1'b0, "R3");
    rx_send(9'h081, 1'b0, 1'b1);
    exp_rx(9'h081, 1'b1, 1'b0, "R7");
    rx_send(9'h081, 1'b1, 1'b1);
    drain();
    cfg_parity = 2'b10;
    tx_put(9'h007, 1'b1, "R3");
    exp_rx(9'h003, 1'b0, 1'b0, "R3");
    rx_send(9'h003, 1'b0, 1'b1);
    drain();

    // R3 parity setting ignored in 9-bit frames
    cfg_nine_bit = 1'b1;
    cfg_parity = 2'b01;
    tx_put(9'h1F0, 1'b1, "R3");
    exp_rx(9'h155, 1'b0, 1'b0, "R3");
    rx_send(9'h155, 1'b0, 1'b1);
    drain();
    cfg_nine_bit = 1'b0;
    cfg_parity = 2'b00;

    // R1 / R4 slower divisor, two stop bits, back-to-back
    cfg_divisor = 16'd4;
    cfg_two_stop = 1'b1;
    tx_put(9'h011, 1'b1, "R4");
    tx_put(9'h022, 1'b1, "R4");
    tx_put(9'h033, 1'b1, "R1");
    exp_rx(9'h096, 1'b0, 1'b0, "R1");
    rx_send(9'h096, 1'b0, 1'b1);
    drain();
    cfg_divisor = 16'd1;
    cfg_two_stop = 1'b0;

    // R7 framing error
    exp_rx(9'h044, 1'b0, 1'b1, "R7");
    rx_send(9'h044, 1'b0, 1'b0);
    exp_rx(9'h045, 1'b0, 1'b0, "R7");
    rx_send(9'h045, 1'b0, 1'b1);
    drain();

    // R5 transmit buffer depth: six writes, sixth dropped
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      tx_data  = 9'(8'h60 + i);
      tx_write = 1'b1;
      if (i < 5) begin
        txq.push_back(9'(8'h60 + i));
        txtag.push_back("R5");
      end
      @(negedge clk);
    end
    tx_write = 1'b0;
    chk("R5", "tx_full after burst", int'(tx_full), 1);
    @(negedge clk);
    chk("R9", "tx_irq when full", int'(tx_irq), 0);
    drain();
    chk("R5", "tx_full after drain", int'(tx_full), 0);
    chk("R9", "tx_irq after drain", int'(tx_irq), 1);

    // R6 receive overrun
    mon_en = 1'b0;
    for (int i = 0; i < 4; i++) rx_send(9'(8'h70 + i), 1'b0, 1'b1);
    chk("R6", "no overrun at four", int'(rx_overrun), 0);
    chk("R9", "rx_irq with data", int'(rx_irq), 1);
    rx_send(9'h0EE, 1'b0, 1'b1);
    chk("R6", "overrun on fifth", int'(rx_overrun), 1);
    for (int i = 0; i < 4; i++) exp_rx(9'(8'h70 + i), 1'b0, 1'b0, "R6");
    mon_en = 1'b1;
    drain();
    chk("R6", "overrun sticky", int'(rx_overrun), 1);
    @(negedge clk);
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
    @(negedge clk);
    chk("R6", "overrun cleared", int'(rx_overrun), 0);

    // R8 address detect
    cfg_addr_detect = 1'b1;
    mon_en = 1'b0;
    rx_send(9'h023, 1'b0, 1'b1);
    chk("R8", "data frame not stored", int'(rx_empty), 1);
    chk("R8", "no rx_irq for data frame", int'(rx_irq), 0);
    rx_send(9'h1A7, 1'b0, 1'b1);
    chk("R8", "address frame stored", int'(rx_empty), 0);
    chk("R8", "rx_irq for address frame", int'(rx_irq), 1);
    exp_rx(9'h1A7, 1'b0, 1'b0, "R8");
    mon_en = 1'b1;
    drain();
    cfg_addr_detect = 1'b0;

    // R12 short low pulse on idle line
    @(negedge clk);
    rxd = 1'b0;
    wait_clks(2);
    rxd = 1'b1;
    wait_clks(3 * bit_clks());
    chk("R12", "glitch ignored", int'(rx_empty), 1);
    exp_rx(9'h0C3, 1'b0, 1'b0, "R12");
    rx_send(9'h0C3, 1'b0, 1'b1);
    drain();

    // R10 loopback
    cfg_loopback = 1'b1;
    wait_clks(2);
    exp_rx(9'h06E, 1'b0, 1'b0, "R10");
    tx_put(9'h06E, 1'b0, "R10");
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 12 * bit_clks(); i++) begin
        @(negedge clk);
        if (txd !== 1'b1) lows++;
      end
      chk("R10", "txd low samples in loopback", lows, 0);
    end
    drain();
    cfg_loopback = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule